// File: doc/BRIEF.md
# Interlocked Asynchronous Read Link

This block joins a requesting side and a responding memory side that run on unrelated clocks. It moves one read across a bus that carries no shared clock. The requester raises the address, the memory-select strobe and the read strobe. After a settling interval it raises the request-sync strobe. The responder waits out its read latency, drives the data and raises the reply-sync strobe. The requester captures the data and drops request-sync. The responder then drops reply-sync and releases the data bus. Each strobe change is caused by the previous change on the other strobe, so a fast responder finishes sooner than a slow one. Each side re-times the strobe it receives through a two-flop synchronizer before it acts on it.

On the requester side, requests enter through a valid/ready pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been consumed and the reply-sync strobe has been seen low again. Results leave through a valid/ready pair. `rsp_valid` and `rsp_data` hold steady until a clock edge where `rsp_ready` is high, and no new request is taken while a response waits. On the responder side, a combinational memory port presents the bus address and takes back the word. The read latency in responder clock cycles is a runtime input, so one build can model a range of memory speeds.

Top module: `async_read_link`

## Requirements
- R1: Once reset is released, `req_ready` is 1. `rsp_valid`, `bus_mreq`, `bus_rd`, `bus_msyn`, `bus_ssyn` and `bus_data_oe` are all 0.
- R2: `bus_msyn` rises only after `bus_mreq` and `bus_rd` have been high for at least `SETUP_CYC` requester cycles. At that moment `mem_addr` equals the accepted `req_addr`. While `bus_msyn` is high, `bus_mreq` and `bus_rd` are also high.
- R3: `bus_ssyn` rises on the (`rd_lat`+4)-th responder rising edge after `bus_msyn` rises. The four extra edges are two synchronizer stages, one decode edge and one final capture edge.
- R4: `rsp_data` equals the `mem_rdata` word for the presented address. `bus_data_oe` is high whenever `bus_ssyn` is high.
- R5: `bus_ssyn` rises only while `bus_msyn` is high. `bus_msyn` falls only while `bus_ssyn` is high. `bus_ssyn` falls only after `bus_msyn` is low.
- R6: `bus_msyn` never rises while `bus_ssyn` is high. `req_ready` is 0 while a response is pending or a transfer is open.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` is unchanged. One edge with `rsp_ready` high clears `rsp_valid`.
- R8: `rd_lat` is sampled when the responder first sees request-sync. Every value from 0 to 2^`LW`-1 gives the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_data | output | DW | Read result |
| rd_lat | input | LW | Responder read latency, in responder cycles |
| mem_addr | output | AW | Address presented on the bus to memory |
| mem_rdata | input | DW | Memory word for `mem_addr` |
| bus_mreq | output | 1 | Memory-select strobe |
| bus_rd | output | 1 | Read strobe |
| bus_msyn | output | 1 | Request-sync strobe |
| bus_ssyn | output | 1 | Reply-sync strobe |
| bus_data_oe | output | 1 | Responder is driving the data bus |

## Verification
The bench sweeps every latency value against addresses that change with the latency. It counts responder edges from request-sync to reply-sync, so an extra or missing synchronizer stage or an off-by-one latency counter shows up as a wrong count. Event monitors on both strobe edges catch a responder that releases before the requester drops request-sync, or a requester that starts a new transfer while reply-sync is still high; either would let stale data be captured. Responses are held off for varying numbers of cycles to expose a result that is overwritten or dropped under back-pressure.

// File: rtl/async_read_link_pkg.sv
package async_read_link_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_SYNC  = 2'd2,
    M_CLOSE = 2'd3
  } m_state_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_READ = 2'd1,
    S_HOLD = 2'd2
  } s_state_t;
endpackage

// File: rtl/alink_sync.sv
module alink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/alink_master.sv
module alink_master
  import async_read_link_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          ssyn_in,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic          bus_msyn
);
  localparam int SCW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  m_state_t       state;
  logic [SCW-1:0] cnt;
  logic           ssyn_s;

  alink_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ssyn_in), .q(ssyn_s)
  );

  assign req_ready = (state == M_IDLE) && !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_IDLE;
      cnt       <= '0;
      bus_addr  <= '0;
      bus_mreq  <= 1'b0;
      bus_rd    <= 1'b0;
      bus_msyn  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        M_IDLE: if (req_valid && req_ready) begin
          bus_addr <= req_addr;
          bus_mreq <= 1'b1;
          bus_rd   <= 1'b1;
          cnt      <= SCW'(SETUP_CYC - 1);
          state    <= M_SETUP;
        end
        M_SETUP: begin
          if (cnt == '0) begin
            bus_msyn <= 1'b1;
            state    <= M_SYNC;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        M_SYNC: if (ssyn_s) begin
          rsp_data  <= bus_data;
          rsp_valid <= 1'b1;
          bus_msyn  <= 1'b0;
          bus_mreq  <= 1'b0;
          bus_rd    <= 1'b0;
          state     <= M_CLOSE;
        end
        M_CLOSE: if (!ssyn_s) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alink_slave.sv
module alink_slave
  import async_read_link_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LW       = 4,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_lat,
  input  logic          msyn_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_ssyn,
  output logic          bus_data_oe,
  output logic [DW-1:0] bus_data
);
  s_state_t      state;
  logic [LW-1:0] cnt;
  logic [DW-1:0] dat;
  logic          msyn_s;

  alink_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(msyn_in), .q(msyn_s)
  );

  assign bus_data = bus_data_oe ? dat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      dat         <= '0;
      bus_ssyn    <= 1'b0;
      bus_data_oe <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (msyn_s) begin
          cnt   <= rd_lat;
          state <= S_READ;
        end
        S_READ: begin
          if (cnt == '0) begin
            dat         <= mem_rdata;
            bus_ssyn    <= 1'b1;
            bus_data_oe <= 1'b1;
            state       <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: if (!msyn_s) begin
          bus_ssyn    <= 1'b0;
          bus_data_oe <= 1'b0;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int LW        = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic [LW-1:0] rd_lat,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic          bus_msyn,
  output logic          bus_ssyn,
  output logic          bus_data_oe
);
  localparam int SYNC_STG = 2;

  logic [DW-1:0] bus_data;

  alink_master #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .SYNC_STG(SYNC_STG)) u_master (
    .clk(clk_m), .rst_n(rst_m_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ssyn_in(bus_ssyn), .bus_data(bus_data),
    .bus_addr(mem_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_msyn(bus_msyn)
  );

  alink_slave #(.DW(DW), .LW(LW), .SYNC_STG(SYNC_STG)) u_slave (
    .clk(clk_s), .rst_n(rst_s_n), .rd_lat(rd_lat),
    .msyn_in(bus_msyn), .mem_rdata(mem_rdata),
    .bus_ssyn(bus_ssyn), .bus_data_oe(bus_data_oe), .bus_data(bus_data)
  );
endmodule

// File: rtl/async_read_link_chk.sv
module async_read_link_chk #(
  parameter int DW = 16
) (
  input logic          clk_m,
  input logic          rst_m_n,
  input logic          clk_s,
  input logic          rst_s_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          bus_mreq,
  input logic          bus_rd,
  input logic          bus_msyn,
  input logic          bus_ssyn,
  input logic          bus_data_oe
);
  p_strobes_with_sync_r2: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    bus_msyn |-> (bus_mreq && bus_rd));

  p_setup_before_sync_r2: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $rose(bus_msyn) |-> $past(bus_mreq));

  p_no_restart_r6: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    $rose(bus_msyn) |-> !bus_ssyn);

  p_busy_not_ready_r6: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (rsp_valid || bus_msyn) |-> !req_ready);

  p_rsp_hold_r7: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_oe_with_ssyn_r4: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    bus_ssyn |-> bus_data_oe);

  p_ssyn_rise_r5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(bus_ssyn) |-> bus_msyn);

  p_ssyn_release_r5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $fell(bus_ssyn) |-> !bus_msyn);
endmodule

bind async_read_link async_read_link_chk #(.DW(DW)) u_chk (
  .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
  .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_data_oe(bus_data_oe)
);

// File: tb/tb_async_read_link.sv
`timescale 1ns/100ps
module tb_async_read_link;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int SETUP_CYC = 2;

  logic clk_m = 1'b0, clk_s = 1'b0;
  logic rst_m_n = 1'b0, rst_s_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] rd_lat = '0;
  logic req_ready, rsp_valid, bus_mreq, bus_rd, bus_msyn, bus_ssyn, bus_data_oe;
  logic [DW-1:0] rsp_data, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  int run = 0, lat_meas = 0, strobe_cnt = 0;
  bit live = 1'b0, done = 1'b0;
  logic [AW-1:0] cur_addr = '0;

  always #2.5 clk_m = ~clk_m;
  initial begin
    #0.7;
    forever begin clk_s = ~clk_s; #3; end
  end

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 8'h3C, a + 8'h17};
  endfunction
  assign mem_rdata = mem_word(mem_addr);

  async_read_link #(.AW(AW), .DW(DW), .LW(LW), .SETUP_CYC(SETUP_CYC)) dut (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_lat(rd_lat), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_msyn(bus_msyn),
    .bus_ssyn(bus_ssyn), .bus_data_oe(bus_data_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // responder edges from request-sync rise to reply-sync rise
  always @(posedge clk_s) begin
    if (bus_msyn && !bus_ssyn) run++;
    else if (!bus_msyn) run = 0;
  end
  // strobe cycles with memory-select high before request-sync
  always @(posedge clk_m) begin
    if (bus_mreq && !bus_msyn) strobe_cnt++;
    else if (!bus_mreq) strobe_cnt = 0;
  end

  always @(posedge bus_ssyn) if (live) begin
    lat_meas = run;
    chk(bus_msyn === 1'b1, "R5 ssyn rose without msyn", int'(bus_msyn), 1);
    chk(bus_data_oe === 1'b1, "R4 data enable with ssyn", int'(bus_data_oe), 1);
  end
  always @(posedge bus_msyn) if (live) begin
    chk(bus_mreq && bus_rd, "R2 strobes before msyn", int'({bus_mreq, bus_rd}), 3);
    chk(strobe_cnt >= SETUP_CYC, "R2 setup cycles", strobe_cnt, SETUP_CYC);
    chk(mem_addr == cur_addr, "R2 address on bus", int'(mem_addr), int'(cur_addr));
    chk(bus_ssyn === 1'b0, "R6 msyn rose while ssyn high", int'(bus_ssyn), 0);
  end
  always @(negedge bus_msyn) if (live)
    chk(bus_ssyn === 1'b1, "R5 msyn fell before ssyn", int'(bus_ssyn), 1);
  always @(negedge bus_ssyn) if (live)
    chk(bus_msyn === 1'b0, "R5 ssyn fell while msyn high", int'(bus_msyn), 0);

  task automatic do_read(input logic [AW-1:0] a, input int lat_v, input int hold);
    logic [DW-1:0] first;
    rd_lat = LW'(lat_v);
    cur_addr = a;
    @(negedge clk_m);
    req_valid = 1'b1;
    req_addr = a;
    while (!req_ready) @(negedge clk_m);
    @(negedge clk_m);
    req_valid = 1'b0;
    req_addr = ~a;
    chk(req_ready == 1'b0, "R6 ready low after accept", int'(req_ready), 0);
    while (!rsp_valid) @(negedge clk_m);
    chk(rsp_data == mem_word(a), "R4 read data", int'(rsp_data), int'(mem_word(a)));
    chk(lat_meas == lat_v + 4, "R3 R8 reply latency", lat_meas, lat_v + 4);
    first = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_m);
      chk(rsp_valid && rsp_data == first, "R7 held response", int'(rsp_data), int'(first));
      chk(req_ready == 1'b0, "R6 ready while pending", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk_m);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R7 response consumed", int'(rsp_valid), 0);
    while (!req_ready) @(negedge clk_m);
    chk(bus_ssyn == 1'b0 && bus_msyn == 1'b0, "R6 bus idle before next",
        int'({bus_msyn, bus_ssyn}), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk_m);
    rst_m_n = 1'b1;
    rst_s_n = 1'b1;
    @(negedge clk_m);
    live = 1'b1;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    chk({bus_mreq, bus_rd, bus_msyn, bus_ssyn, bus_data_oe} == 5'b0,
        "R1 bus idle after reset", int'({bus_mreq, bus_rd, bus_msyn, bus_ssyn, bus_data_oe}), 0);
    for (int l = 0; l < (1 << LW); l++) begin
      do_read(AW'(l * 17), l, l % 3);
      do_read(AW'(8'hFF - l), l, 0);
      do_read(AW'(l * 53 + 9), (1 << LW) - 1 - l, 4);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_m);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule